// File: doc/BRIEF.md
# Post-Increment Load/Store Address Generator

This block forms the memory address for a load/store path that offers exactly two ways of addressing: the address is the base register value as read, or it is that same value and the base register is then stepped forward by the access width. There is no displacement adder. The address leaves the block with no logic on the path from the register read. This lets the memory access take place in the stage right after decode and register fetch, ahead of execute.

A separate incrementer produces the stepped base value at the same time. A writeback strobe tells a second register-file write port to store it. The block also produces per-byte lane enables for a 32-bit data path and flags two conditions that cancel the base update. The first is an access that is not aligned to its own width. The second is an illegal request: a post-increment load whose destination is its own base register, or an unused width code.

Top module: `aiu_addr_unit`

## Requirements
- R1: `addr_o` always equals `base_i`, in both modes and whatever the other inputs are.
- R2: In plain indirect mode (`mode_i`=0), `base_wb_o` stays low.
- R3: `base_next_o` is `base_i` plus the access width in bytes: width code 0 adds 1, code 1 adds 2, code 2 adds 4. For a legal, aligned post-increment request (`mode_i`=1, `valid_i`=1), `base_wb_o` is high.
- R4: The stepped base wraps modulo 2^32. For example, 0xFFFFFFFC plus 4 gives 0.
- R5: Lane enables use bit k for byte k of the word, where byte k is selected by address bits [1:0]. A byte access enables bit addr[1:0]. A halfword access enables 2'b11 shifted left by addr[1:0]. A word access enables 4'hF.
- R6: A halfword with addr[0]=1, or a word with addr[1:0]≠0, raises `misalign_o`. The lane enables are then 0 and `base_wb_o` is low.
- R7: A post-increment load (`is_load_i`=1) with `dest_idx_i`==`base_idx_i` raises `illegal_o` and holds `base_wb_o` low. A store, or an indirect load, with equal indices is legal.
- R8: Width code 3 is reserved. It raises `illegal_o`, gives lane enables of 0, leaves `misalign_o` low and holds `base_wb_o` low.
- R9: With `valid_i` low, `be_o` is 0 and `base_wb_o`, `misalign_o` and `illegal_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| mode_i | input | 1 | 0 = indirect, 1 = post-increment |
| is_load_i | input | 1 | 1 = load, 0 = store |
| size_i | input | 2 | Width code: 0 byte, 1 half, 2 word, 3 reserved |
| base_i | input | 32 | Base register value |
| base_idx_i | input | 5 | Base register index |
| dest_idx_i | input | 5 | Load destination register index |
| addr_o | output | 32 | Memory address |
| base_next_o | output | 32 | Stepped base value |
| base_wb_o | output | 1 | Write `base_next_o` back to the base register |
| be_o | output | 4 | Byte lane enables |
| misalign_o | output | 1 | Access not aligned to its width |
| illegal_o | output | 1 | Destination clash or reserved width |

## Verification
The hardest situations to reach are the ones where several suppressions meet the wrap. Examples are a byte access at the top of the address space, where the step wraps while the lane sits in the last byte, and a post-increment load that is aligned but names its own base as destination. The stimulus places base values at 0xFFFFFFFC and 0xFFFFFFFF. It then drives the same register index into both index ports, first as a load and then as a store, in both modes. This separates the clash check from the mode and direction checks.

// File: rtl/aiu_pkg.sv
package aiu_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_RSVD = 2'd3;

  localparam logic MODE_IND  = 1'b0;
  localparam logic MODE_AINC = 1'b1;

  // bytes moved by one access; 0 for the reserved code
  function automatic logic [3:0] sz_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: sz_bytes = 4'd1;
      SZ_HALF: sz_bytes = 4'd2;
      SZ_WORD: sz_bytes = 4'd4;
      default: sz_bytes = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/aiu_incr.sv
module aiu_incr
  import aiu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] step;

  assign step   = ADDR_W'(sz_bytes(size_i));
  assign next_o = base_i + step;

  p_step_pow2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i != SZ_RSVD) |-> ($countones(next_o - base_i) == 1));
endmodule

// File: rtl/aiu_lane_dec.sv
module aiu_lane_dec
  import aiu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               size_i,
  input  logic [$clog2(LANES)-1:0] off_i,
  output logic [LANES-1:0]         be_o,
  output logic                     misalign_o
);
  logic [3:0]       bytes;
  logic [3:0]       off4;
  logic [LANES-1:0] span;

  assign bytes      = sz_bytes(size_i);
  assign off4       = 4'(off_i);
  assign misalign_o = valid_i && (size_i != SZ_RSVD) && ((off4 & (bytes - 4'd1)) != 4'd0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign span[i] = (4'(i) >= off4) && (4'(i) < off4 + bytes);
  end

  assign be_o = (valid_i && !misalign_o) ? span : '0;

  p_be_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(be_o) == 0) || ($countones(be_o) == 1) ||
    ($countones(be_o) == 2) || ($countones(be_o) == 4));
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (be_o == '0) && !misalign_o);
endmodule

// File: rtl/aiu_hazard.sv
module aiu_hazard
  import aiu_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             valid_i,
  input  logic             mode_i,
  input  logic             is_load_i,
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [IDX_W-1:0] dest_idx_i,
  output logic             illegal_o
);
  logic clash;

  // two writes to one register in a single instruction
  assign clash     = (mode_i == MODE_AINC) && is_load_i && (base_idx_i == dest_idx_i);
  assign illegal_o = valid_i && (clash || (size_i == SZ_RSVD));
endmodule

// File: rtl/aiu_addr_unit.sv
module aiu_addr_unit
  import aiu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              is_load_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] base_next_o,
  output logic              base_wb_o,
  output logic [LANES-1:0]  be_o,
  output logic              misalign_o,
  output logic              illegal_o
);
  localparam int OFF_W = $clog2(LANES);

  // no adder on the address path
  assign addr_o = base_i;

  aiu_incr #(.ADDR_W(ADDR_W)) u_incr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (size_i),
    .base_i (base_i),
    .next_o (base_next_o)
  );

  aiu_lane_dec #(.LANES(LANES)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .size_i     (size_i),
    .off_i      (base_i[OFF_W-1:0]),
    .be_o       (be_o),
    .misalign_o (misalign_o)
  );

  aiu_hazard #(.IDX_W(IDX_W)) u_haz (
    .valid_i    (valid_i),
    .mode_i     (mode_i),
    .is_load_i  (is_load_i),
    .size_i     (size_i),
    .base_idx_i (base_idx_i),
    .dest_idx_i (dest_idx_i),
    .illegal_o  (illegal_o)
  );

  assign base_wb_o = valid_i && (mode_i == MODE_AINC) && !misalign_o && !illegal_o;

  p_no_wb_indirect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IND) |-> !base_wb_o);
  p_misalign_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !base_wb_o && (be_o == '0));
  p_illegal_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !base_wb_o);
  p_rsvd_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_RSVD) |-> illegal_o && !misalign_o && (be_o == '0));
  p_idle_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !base_wb_o && !illegal_o);
endmodule

// File: tb/aiu_addr_unit_bench.sv
module aiu_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, mode = 1'b0, is_load = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] base = '0;
  logic [4:0]  bidx = '0, didx = '0;
  logic [31:0] addr, bnext;
  logic        wb, mis, ill;
  logic [3:0]  be;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  aiu_addr_unit u_aiu_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .is_load_i(is_load),
    .size_i(size), .base_i(base), .base_idx_i(bidx), .dest_idx_i(didx),
    .addr_o(addr), .base_next_o(bnext), .base_wb_o(wb), .be_o(be),
    .misalign_o(mis), .illegal_o(ill)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic m, input logic ld, input logic [1:0] sz,
                       input logic [31:0] b, input logic [4:0] bi, input logic [4:0] di);
    @(negedge clk);
    valid = v; mode = m; is_load = ld; size = sz; base = b; bidx = bi; didx = di;
    #1;
  endtask

  task automatic t_reset;
    chk("R9 reset be", 32'(be), 32'h0);
    chk("R9 reset wb", 32'(wb), 32'h0);
    chk("R9 reset ill", 32'(ill), 32'h0);
  endtask

  task automatic t_indirect;
    drive(1, 0, 1, 2'd2, 32'h4000, 5'd1, 5'd2);
    chk("R1 ind addr", addr, 32'h4000);
    chk("R2 ind wb", 32'(wb), 32'h0);
    chk("R5 ind be", 32'(be), 32'hF);
    drive(1, 0, 0, 2'd0, 32'h4002, 5'd1, 5'd2);
    chk("R2 ind store wb", 32'(wb), 32'h0);
    chk("R5 ind byte be", 32'(be), 32'h4);
  endtask

  task automatic t_autoinc;
    drive(1, 1, 0, 2'd2, 32'h1000, 5'd1, 5'd2);
    chk("R1 ainc addr", addr, 32'h1000);
    chk("R3 word next", bnext, 32'h1004);
    chk("R3 word wb", 32'(wb), 32'h1);
    drive(1, 1, 1, 2'd1, 32'h2002, 5'd1, 5'd2);
    chk("R3 half next", bnext, 32'h2004);
    chk("R5 half be", 32'(be), 32'hC);
    chk("R3 half wb", 32'(wb), 32'h1);
    drive(1, 1, 1, 2'd0, 32'h3003, 5'd4, 5'd5);
    chk("R3 byte next", bnext, 32'h3004);
    chk("R5 byte be", 32'(be), 32'h8);
  endtask

  task automatic t_wrap;
    drive(1, 1, 0, 2'd2, 32'hFFFF_FFFC, 5'd1, 5'd2);
    chk("R4 word wrap", bnext, 32'h0);
    chk("R4 word wrap wb", 32'(wb), 32'h1);
    drive(1, 1, 1, 2'd0, 32'hFFFF_FFFF, 5'd1, 5'd2);
    chk("R4 byte wrap", bnext, 32'h0);
    chk("R5 top byte be", 32'(be), 32'h8);
  endtask

  task automatic t_misalign;
    drive(1, 1, 0, 2'd1, 32'h5001, 5'd1, 5'd2);
    chk("R6 half mis", 32'(mis), 32'h1);
    chk("R6 half be", 32'(be), 32'h0);
    chk("R6 half wb", 32'(wb), 32'h0);
    drive(1, 1, 0, 2'd2, 32'h5002, 5'd1, 5'd2);
    chk("R6 word mis", 32'(mis), 32'h1);
    chk("R6 word wb", 32'(wb), 32'h0);
    drive(1, 1, 0, 2'd0, 32'h5003, 5'd1, 5'd2);
    chk("R6 byte no mis", 32'(mis), 32'h0);
  endtask

  task automatic t_clash;
    drive(1, 1, 1, 2'd2, 32'h6000, 5'd3, 5'd3);
    chk("R7 load clash ill", 32'(ill), 32'h1);
    chk("R7 load clash wb", 32'(wb), 32'h0);
    drive(1, 1, 0, 2'd2, 32'h6000, 5'd3, 5'd3);
    chk("R7 store same ill", 32'(ill), 32'h0);
    chk("R7 store same wb", 32'(wb), 32'h1);
    drive(1, 0, 1, 2'd2, 32'h6000, 5'd3, 5'd3);
    chk("R7 ind load ill", 32'(ill), 32'h0);
  endtask

  task automatic t_reserved;
    drive(1, 1, 0, 2'd3, 32'h7000, 5'd1, 5'd2);
    chk("R8 rsvd ill", 32'(ill), 32'h1);
    chk("R8 rsvd be", 32'(be), 32'h0);
    chk("R8 rsvd mis", 32'(mis), 32'h0);
    chk("R8 rsvd wb", 32'(wb), 32'h0);
  endtask

  task automatic t_idle;
    drive(0, 1, 1, 2'd1, 32'h8001, 5'd3, 5'd3);
    chk("R9 idle be", 32'(be), 32'h0);
    chk("R9 idle wb", 32'(wb), 32'h0);
    chk("R9 idle mis", 32'(mis), 32'h0);
    chk("R9 idle ill", 32'(ill), 32'h0);
    chk("R1 idle addr", addr, 32'h8001);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_indirect();
    t_autoinc();
    t_wrap();
    t_misalign();
    t_clash();
    t_reserved();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule